// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the address of the next instruction to fetch and moves it forward on every clock cycle in which the control logic asks it to. A cycle can step the address by one, load it with an absolute target, load it with a target only when a selected status flag is true, enter a subroutine, leave one, or enter an interrupt handler at a supplied vector. All requests are one-cycle strobes. The address changes on the clock edge that samples a strobe.

Subroutine calls and interrupt entries save their return address in a small on-chip last-in first-out store. A return restores the address from that store. The number of entries in the store is a parameter. It is the hard limit on nesting: with three entries, three levels of calls and interrupts can be open at the same time. A save attempted on a full store is refused and raises a sticky overflow flag. A restore attempted on an empty store is refused and raises a sticky underflow flag. Both flags stay set until the block is cleared.

The surrounding control logic presents one command per cycle. When several strobes arrive together, a fixed priority picks one of them and the rest are dropped.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `depth_o` is 0, and `ovf_o` and `unf_o` are both 0. The reset is applied asynchronously and released in step with the clock.
- R2: An `step_i` strobe with no stronger command sets `pc_o` to `pc_o`+1 modulo 2^ADDR_W, so 16'hFFFF steps to 16'h0000.
- R3: A `jump_i` strobe loads `pc_o` with `target_i`.
- R4: A `cjump_i` strobe loads `target_i` when `flags_i[cond_i]` is 1 and otherwise steps `pc_o` by one. The flag positions are bit 0 carry, bit 1 zero, bit 2 sign and bit 3 parity.
- R5: A `call_i` strobe on a stack that is not full saves `pc_o`+1, loads `target_i` and raises `depth_o` by one.
- R6: A `ret_i` strobe on a stack that is not empty loads `pc_o` from the most recently saved entry and lowers `depth_o` by one. Entries come back in last-in first-out order, up to DEPTH levels.
- R7: An `irq_i` strobe on a stack that is not full saves the current `pc_o` unchanged, loads `vector_i` and raises `depth_o` by one.
- R8: A call or interrupt entry on a full stack sets `ovf_o`. `pc_o` and the stack are left unchanged. `ovf_o` stays set until a clear.
- R9: A return on an empty stack sets `unf_o` and leaves `pc_o` unchanged. `unf_o` stays set until a clear.
- R10: When several strobes arrive in the same cycle, the priority is `clear_i` > `irq_i` > `ret_i` > `call_i` > `jump_i` > `cjump_i` > `step_i`. Only the strongest one acts.
- R11: A `clear_i` strobe returns `pc_o`, `depth_o`, `ovf_o` and `unf_o` to 0 on the next edge.
- R12: In a cycle with no strobe, `pc_o` and `depth_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| vector_i | input | ADDR_W | Interrupt handler address |
| ret_i | input | 1 | Return strobe |
| call_i | input | 1 | Subroutine call strobe |
| jump_i | input | 1 | Unconditional jump strobe |
| cjump_i | input | 1 | Conditional jump strobe |
| cond_i | input | 2 | Flag select for a conditional jump |
| flags_i | input | 4 | Status flags: {parity, sign, zero, carry} |
| step_i | input | 1 | Sequential step strobe |
| target_i | input | ADDR_W | Jump or call target |
| pc_o | output | ADDR_W | Current program counter |
| depth_o | output | $clog2(DEPTH+1) | Number of saved return addresses |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
Every result is registered. A strobe sampled on one rising edge shows on `pc_o`, `depth_o`, `ovf_o` and `unf_o` just after that same edge, so each result is due one cycle after the stimulus. The exception is reset release, which takes effect two edges after `rst_n` rises because of the release synchronizer.

The bench drives strobes on the falling edge and removes them on the next falling edge. It compares the outputs at that second falling edge, half a cycle after the capturing edge and away from any active edge.

Nesting, overflow and underflow are checked through long call/return chains. The expected addresses are computed from the requirement text.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // One decoded command per cycle, after priority resolution.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP  = 3'd1,
    OP_CJUMP = 3'd2,
    OP_JUMP  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_IRQ   = 3'd6,
    OP_CLEAR = 3'd7
  } pcs_op_e;

  // Flag positions inside the status-flag vector.
  localparam int unsigned FLAG_CARRY  = 0;
  localparam int unsigned FLAG_ZERO   = 1;
  localparam int unsigned FLAG_SIGN   = 2;
  localparam int unsigned FLAG_PARITY = 3;
  localparam int unsigned NUM_FLAGS   = 4;
endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_cmd_arb.sv
module pcs_cmd_arb
  import pcs_pkg::*;
(
  input  logic    clear_i,
  input  logic    irq_i,
  input  logic    ret_i,
  input  logic    call_i,
  input  logic    jump_i,
  input  logic    cjump_i,
  input  logic    step_i,
  output pcs_op_e op_o
);
  // Fixed priority: the strongest strobe present wins.
  always_comb begin
    if      (clear_i) op_o = OP_CLEAR;
    else if (irq_i)   op_o = OP_IRQ;
    else if (ret_i)   op_o = OP_RET;
    else if (call_i)  op_o = OP_CALL;
    else if (jump_i)  op_o = OP_JUMP;
    else if (cjump_i) op_o = OP_CJUMP;
    else if (step_i)  op_o = OP_STEP;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval #(
  parameter int unsigned NFLAG = 4,
  localparam int unsigned SEL_W = $clog2(NFLAG)
) (
  input  logic [NFLAG-1:0] flags_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             taken_o
);
  logic [NFLAG-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_sel
      assign hit[g] = flags_i[g] && (sel_i == SEL_W'(g));
    end
  endgenerate

  assign taken_o = |hit;
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (push_ok) cnt_d = cnt_q + 1'b1;
    else if (pop_ok)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      logic wr_en;
      assign wr_en = push_ok && (cnt_q == CW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ent_q[g] <= '0;
        else if (wr_en) ent_q[g] <= din_i;
      end
    end
  endgenerate

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top_o = ent_q[i];
    end
  end

  assign count_o = cnt_q;

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !clr_i) |=> $stable(cnt_q));

  // R6
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned CW    = $clog2(DEPTH+1),
  localparam int unsigned SEL_W = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 irq_i,
  input  logic [ADDR_W-1:0]    vector_i,
  input  logic                 ret_i,
  input  logic                 call_i,
  input  logic                 jump_i,
  input  logic                 cjump_i,
  input  logic [SEL_W-1:0]     cond_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 step_i,
  input  logic [ADDR_W-1:0]    target_i,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [CW-1:0]        depth_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  logic              rst_sync_n;
  pcs_op_e           op;
  logic              taken;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic              ovf_q, ovf_d, unf_q, unf_d;
  logic              push, pop, stk_clr, full, empty;
  logic [ADDR_W-1:0] push_data, top;
  logic [CW-1:0]     depth;

  pcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcs_cmd_arb u_arb (
    .clear_i (clear_i),
    .irq_i   (irq_i),
    .ret_i   (ret_i),
    .call_i  (call_i),
    .jump_i  (jump_i),
    .cjump_i (cjump_i),
    .step_i  (step_i),
    .op_o    (op)
  );

  pcs_cond_eval #(.NFLAG(NUM_FLAGS)) u_cond (
    .flags_i (flags_i),
    .sel_i   (cond_i),
    .taken_o (taken)
  );

  pcs_ret_stack #(.DW(ADDR_W), .DEPTH(DEPTH)) u_stk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (stk_clr),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (push_data),
    .top_o   (top),
    .count_o (depth),
    .full_o  (full),
    .empty_o (empty)
  );

  assign pc_inc = pc_q + 1'b1;

  // Next-state selection.
  always_comb begin
    pc_d      = pc_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    push      = 1'b0;
    pop       = 1'b0;
    stk_clr   = 1'b0;
    push_data = pc_inc;
    unique case (op)
      OP_CLEAR: begin
        pc_d    = '0;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        stk_clr = 1'b1;
      end
      OP_IRQ: begin
        push_data = pc_q;
        if (full) ovf_d = 1'b1;
        else begin
          push = 1'b1;
          pc_d = vector_i;
        end
      end
      OP_RET: begin
        if (empty) unf_d = 1'b1;
        else begin
          pop  = 1'b1;
          pc_d = top;
        end
      end
      OP_CALL: begin
        if (full) ovf_d = 1'b1;
        else begin
          push = 1'b1;
          pc_d = target_i;
        end
      end
      OP_JUMP:  pc_d = target_i;
      OP_CJUMP: pc_d = taken ? target_i : pc_inc;
      OP_STEP:  pc_d = pc_inc;
      default:  pc_d = pc_q;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign pc_o    = pc_q;
  assign depth_o = depth;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !clear_i && !irq_i && !ret_i && !call_i && !jump_i && !cjump_i)
      |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_q && !clear_i) |=> ovf_q);

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unf_q && !clear_i) |=> unf_q);

  // R9
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_i && empty && !clear_i && !irq_i) |=> $stable(pc_q));

  // R5
  call_depth_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && !full && !clear_i && !irq_i && !ret_i)
      |=> (depth == $past(depth) + 1'b1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(clear_i || irq_i || ret_i || call_i || jump_i || cjump_i || step_i)
      |=> ($stable(pc_q) && $stable(depth)));
endmodule

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DEPTH  = 3;
  localparam int unsigned CW     = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n;
  logic clear_i, irq_i, ret_i, call_i, jump_i, cjump_i, step_i;
  logic [ADDR_W-1:0] vector_i, target_i;
  logic [1:0] cond_i;
  logic [3:0] flags_i;
  logic [ADDR_W-1:0] pc_o;
  logic [CW-1:0] depth_o;
  logic ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pc_sequencer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .irq_i(irq_i),
    .vector_i(vector_i), .ret_i(ret_i), .call_i(call_i), .jump_i(jump_i),
    .cjump_i(cjump_i), .cond_i(cond_i), .flags_i(flags_i), .step_i(step_i),
    .target_i(target_i), .pc_o(pc_o), .depth_o(depth_o), .ovf_o(ovf_o),
    .unf_o(unf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    clear_i = 0; irq_i = 0; ret_i = 0; call_i = 0; jump_i = 0;
    cjump_i = 0; step_i = 0;
  endtask

  // Strobes were set at a falling edge; the rising edge samples them,
  // the next falling edge removes them and outputs are compared there.
  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_jump(input logic [15:0] a);
    jump_i = 1; target_i = a; tick();
  endtask

  task automatic do_call(input logic [15:0] a);
    call_i = 1; target_i = a; tick();
  endtask

  task automatic do_ret();
    ret_i = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_o, 0);
    chk("R1 depth", depth_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 unf", unf_o, 0);
  endtask

  task automatic t_step();
    repeat (3) begin step_i = 1; tick(); end
    chk("R2 step x3", pc_o, 16'h0003);
    do_jump(16'hFFFE);
    step_i = 1; tick();
    chk("R2 step", pc_o, 16'hFFFF);
    step_i = 1; tick();
    chk("R2 wrap", pc_o, 16'h0000);
  endtask

  task automatic t_jump();
    do_jump(16'h1234);
    chk("R3 jump", pc_o, 16'h1234);
  endtask

  task automatic t_cjump();
    flags_i = 4'b0001; cond_i = 2'd0; cjump_i = 1; target_i = 16'h2000; tick();
    chk("R4 carry taken", pc_o, 16'h2000);
    cond_i = 2'd1; cjump_i = 1; target_i = 16'h9999; tick();
    chk("R4 zero not taken", pc_o, 16'h2001);
    flags_i = 4'b0010; cond_i = 2'd1; cjump_i = 1; target_i = 16'h3000; tick();
    chk("R4 zero taken", pc_o, 16'h3000);
    flags_i = 4'b0100; cond_i = 2'd2; cjump_i = 1; target_i = 16'h4000; tick();
    chk("R4 sign taken", pc_o, 16'h4000);
    flags_i = 4'b1000; cond_i = 2'd3; cjump_i = 1; target_i = 16'h5000; tick();
    chk("R4 parity taken", pc_o, 16'h5000);
    flags_i = 4'b0111; cond_i = 2'd3; cjump_i = 1; target_i = 16'h6000; tick();
    chk("R4 parity not taken", pc_o, 16'h5001);
    flags_i = 4'b0000;
  endtask

  task automatic t_nest();
    do_jump(16'h0100);
    do_call(16'h0200);
    chk("R5 call pc", pc_o, 16'h0200);
    chk("R5 call depth", depth_o, 1);
    do_call(16'h0300);
    do_call(16'h0400);
    chk("R5 third level", pc_o, 16'h0400);
    chk("R5 depth full", depth_o, 3);
    do_ret();
    chk("R6 ret level3", pc_o, 16'h0301);
    chk("R6 depth", depth_o, 2);
    do_ret();
    chk("R6 ret level2", pc_o, 16'h0201);
    do_ret();
    chk("R6 ret level1", pc_o, 16'h0101);
    chk("R6 depth empty", depth_o, 0);
  endtask

  task automatic t_underflow();
    do_ret();
    chk("R9 pc kept", pc_o, 16'h0101);
    chk("R9 unf set", unf_o, 1);
    chk("R9 depth", depth_o, 0);
    step_i = 1; tick();
    chk("R9 unf sticky", unf_o, 1);
    chk("R2 after unf", pc_o, 16'h0102);
  endtask

  task automatic t_irq();
    irq_i = 1; vector_i = 16'h0800; tick();
    chk("R7 vector", pc_o, 16'h0800);
    chk("R7 depth", depth_o, 1);
    do_ret();
    chk("R7 resume same pc", pc_o, 16'h0102);
  endtask

  task automatic t_overflow();
    do_call(16'hA000);
    do_call(16'hB000);
    do_call(16'hC000);
    chk("R8 ovf clear before", ovf_o, 0);
    do_call(16'hD000);
    chk("R8 ovf set", ovf_o, 1);
    chk("R8 pc kept", pc_o, 16'hC000);
    chk("R8 depth kept", depth_o, 3);
    irq_i = 1; vector_i = 16'hE000; tick();
    chk("R8 irq on full pc kept", pc_o, 16'hC000);
    do_ret();
    chk("R8 stack intact", pc_o, 16'hB001);
    do_ret();
    do_ret();
    chk("R8 bottom entry", pc_o, 16'h0103);
    chk("R8 ovf sticky", ovf_o, 1);
  endtask

  task automatic t_priority();
    do_jump(16'h0010);
    do_call(16'h0020);
    ret_i = 1; call_i = 1; jump_i = 1; step_i = 1; target_i = 16'h0030; tick();
    chk("R10 ret beats call", pc_o, 16'h0011);
    chk("R10 ret depth", depth_o, 0);
    do_call(16'h0020);
    irq_i = 1; ret_i = 1; vector_i = 16'h0900; tick();
    chk("R10 irq beats ret", pc_o, 16'h0900);
    chk("R10 irq depth", depth_o, 2);
    do_ret();
    chk("R10 irq saved pc", pc_o, 16'h0020);
    call_i = 1; jump_i = 1; target_i = 16'h0040; tick();
    chk("R10 call beats jump depth", depth_o, 2);
    jump_i = 1; cjump_i = 1; step_i = 1; target_i = 16'h0050; flags_i = 4'b0000; tick();
    chk("R10 jump beats cjump", pc_o, 16'h0050);
    cjump_i = 1; step_i = 1; flags_i = 4'b0001; cond_i = 2'd0; target_i = 16'h0060; tick();
    chk("R10 cjump beats step", pc_o, 16'h0060);
    flags_i = 4'b0000;
  endtask

  task automatic t_clear();
    clear_i = 1; irq_i = 1; call_i = 1; step_i = 1; target_i = 16'h7777; tick();
    chk("R11 pc", pc_o, 0);
    chk("R11 depth", depth_o, 0);
    chk("R11 ovf", ovf_o, 0);
    chk("R11 unf", unf_o, 0);
  endtask

  task automatic t_idle();
    do_jump(16'h0077);
    do_call(16'h0088);
    repeat (3) @(negedge clk);
    chk("R12 pc hold", pc_o, 16'h0088);
    chk("R12 depth hold", depth_o, 1);
  endtask

  initial begin
    idle_inputs();
    vector_i = '0; target_i = '0; cond_i = '0; flags_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_step();
    t_jump();
    t_cjump();
    t_nest();
    t_underflow();
    t_irq();
    t_overflow();
    t_priority();
    t_clear();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule